// File: doc/BRIEF.md
# Write-Recovery Precharge Guard

This block watches the command stream of a DDR3-style SDRAM controller. It works out, for each bank, the earliest clock cycle in which a PRECHARGE may follow a WRITE. The earliest cycle is the sum of four terms: the WRITE cycle, the write latency (additive latency plus CAS write latency), the clock cycles the data burst occupies, and the write-recovery count. The recovery count begins on the first rising edge after the last data beat. An eight-beat burst occupies four clocks and a four-beat chopped burst occupies two.

Each bank has its own down-counter. The block shows a per-bank "precharge permitted" bit. It also raises a one-cycle violation pulse when a PRECHARGE reaches a bank that is still recovering, and it keeps the number of the offending bank in a sticky status field. Everything works at clock-cycle resolution. The latency and burst settings are sampled on each WRITE.

Top module: `wrRecoveryGuard`

## Requirements
- R1: Synchronous reset (`rst` high at a rising edge) sets all `preOk` bits high and clears `violation`, `violBank` and `violSticky`.
- R2: A WRITE is `cmdValid` high with `cmdCode` = 3'b001. In fixed eight-beat mode (`cfgBurst` = 2'b00), a WRITE in cycle W makes `preOk[bank]` low from cycle W+1 through cycle W+AL+CWL+4+tWR-1, and high again in cycle W+AL+CWL+4+tWR.
- R3: In fixed chopped mode (`cfgBurst` = 2'b10), the reopening cycle is W+AL+CWL+2+tWR.
- R4: In per-command mode (`cfgBurst` = 2'b01), `cmdA12` = 1 selects the four-clock burst and `cmdA12` = 0 selects the two-clock burst. The code 2'b11 is treated as fixed eight-beat.
- R5: Additive latency adds one-for-one to the reopening cycle, in the same way as CAS write latency.
- R6: Recovery is tracked per bank. A WRITE to one bank leaves every other bank's `preOk` bit unchanged.
- R7: A new WRITE to a bank that is already recovering keeps the later of the pending deadline and the new one. An earlier new deadline never shortens the wait.
- R8: A PRECHARGE is `cmdValid` high with `cmdCode` = 3'b010. A PRECHARGE to a bank whose `preOk` bit is low drives `violation` high for exactly the next cycle. It also loads that bank into `violBank` and sets `violSticky`, and both hold until reset or the next violation.
- R9: A PRECHARGE to a bank whose `preOk` bit is high, including a different bank from one that is recovering, causes no violation and leaves `violBank` and `violSticky` unchanged.
- R10: Any other `cmdCode`, and any command with `cmdValid` low, changes no `preOk` bit and causes no violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmdValid | input | 1 | Command strobe |
| cmdCode | input | 3 | Command code (001 write, 010 precharge) |
| cmdBank | input | 3 | Bank address |
| cmdA12 | input | 1 | Per-command burst select (1 = eight beats) |
| cfgAl | input | 5 | Additive latency in clocks |
| cfgCwl | input | 5 | CAS write latency in clocks |
| cfgBurst | input | 2 | Burst mode (00 eight, 01 per command, 10 chopped) |
| cfgTwr | input | 5 | Write recovery in clocks |
| preOk | output | 8 | Per-bank precharge permitted |
| violation | output | 1 | One-cycle early-precharge pulse |
| violBank | output | 3 | Bank of the latest violation (sticky) |
| violSticky | output | 1 | Set by any violation until reset |

## Verification
The hardest case to reach is a bank with a pending deadline that receives a second WRITE with a shorter configuration. In that case the counter must keep the old, later deadline rather than reload. The bench issues an eight-beat WRITE and then, on the very next cycle, switches the mode to chopped and writes the same bank again. It then measures the reopening cycle against the first WRITE. A second run places a later WRITE a few cycles on, so that the deadline moves out. Violations are produced by issuing a PRECHARGE one cycle after a WRITE to the same bank, and then to a quiet bank.

// File: rtl/wrg_pkg.sv
package wrg_pkg;
  localparam int BANKS  = 8;
  localparam int BANK_W = $clog2(BANKS);
  localparam int CFG_W  = 5;
  localparam int CNT_W  = CFG_W + 2;

  localparam logic [2:0] CMD_WRITE = 3'b001;
  localparam logic [2:0] CMD_PRE   = 3'b010;

  typedef enum logic [1:0] {
    BURST_EIGHT = 2'b00,
    BURST_OTF   = 2'b01,
    BURST_CHOP  = 2'b10,
    BURST_RSVD  = 2'b11
  } burstMode_t;

  typedef struct packed {
    logic              wrHit;
    logic              preHit;
    logic [BANK_W-1:0] bank;
    logic [CNT_W-1:0]  loadVal;
  } ctlStrobe_t;
endpackage

// File: rtl/wrg_control.sv
module wrg_control
  import wrg_pkg::*;
(
  input  logic              cmdValid,
  input  logic [2:0]        cmdCode,
  input  logic [BANK_W-1:0] cmdBank,
  input  logic              cmdA12,
  input  logic [CFG_W-1:0]  cfgAl,
  input  logic [CFG_W-1:0]  cfgCwl,
  input  logic [1:0]        cfgBurst,
  input  logic [CFG_W-1:0]  cfgTwr,
  output ctlStrobe_t        ctl
);
  logic [CNT_W-1:0] burstClk;
  logic [CNT_W-1:0] total;

  always_comb begin
    case (burstMode_t'(cfgBurst))
      BURST_CHOP: burstClk = CNT_W'(2);
      BURST_OTF:  burstClk = cmdA12 ? CNT_W'(4) : CNT_W'(2);
      default:    burstClk = CNT_W'(4);
    endcase
  end

  // deadline relative to the WRITE cycle; counter holds it minus one
  assign total = CNT_W'(cfgAl) + CNT_W'(cfgCwl) + burstClk + CNT_W'(cfgTwr);

  always_comb begin
    ctl.wrHit   = cmdValid && (cmdCode == CMD_WRITE);
    ctl.preHit  = cmdValid && (cmdCode == CMD_PRE);
    ctl.bank    = cmdBank;
    ctl.loadVal = total - CNT_W'(1);
  end
endmodule

// File: rtl/wrg_datapath.sv
module wrg_datapath
  import wrg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  ctlStrobe_t        ctl,
  output logic [BANKS-1:0]  preOk,
  output logic              violation,
  output logic [BANK_W-1:0] violBank,
  output logic              violSticky
);
  logic [CNT_W-1:0] cnt [BANKS];

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [CNT_W-1:0] dec;
    logic             hitMe;
    assign dec   = (cnt[b] == '0) ? '0 : cnt[b] - CNT_W'(1);
    assign hitMe = ctl.wrHit && (ctl.bank == BANK_W'(b));

    always_ff @(posedge clk) begin
      if (rst)                              cnt[b] <= '0;
      else if (hitMe && ctl.loadVal > dec)  cnt[b] <= ctl.loadVal;
      else                                  cnt[b] <= dec;
    end

    assign preOk[b] = (cnt[b] == '0);

    // R7: a rewrite never pulls the deadline in
    p_no_shorten_r7: assert property (@(posedge clk) disable iff (rst)
      (hitMe && cnt[b] > CNT_W'(1)) |=> (cnt[b] >= $past(cnt[b]) - CNT_W'(1)));

    // R6: a bank not written cannot close
    p_bank_isolated_r6: assert property (@(posedge clk) disable iff (rst)
      (!hitMe && preOk[b]) |=> preOk[b]);
  end

  logic early;
  assign early = ctl.preHit && !preOk[ctl.bank];

  always_ff @(posedge clk) begin
    if (rst) begin
      violation  <= 1'b0;
      violBank   <= '0;
      violSticky <= 1'b0;
    end else begin
      violation <= early;
      if (early) begin
        violBank   <= ctl.bank;
        violSticky <= 1'b1;
      end
    end
  end

  // R2: a write closes its bank on the next cycle
  p_write_closes_r2: assert property (@(posedge clk) disable iff (rst)
    ctl.wrHit |=> !preOk[$past(ctl.bank)]);

  // R8: a violation pulse always leaves the sticky bit set
  p_viol_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    violation |-> violSticky);

  // R9: a permitted precharge never flags
  p_ok_no_viol_r9: assert property (@(posedge clk) disable iff (rst)
    (ctl.preHit && preOk[ctl.bank]) |=> !violation);

  // R10: no precharge, no pulse
  p_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !ctl.preHit |=> !violation);
endmodule

// File: rtl/wrRecoveryGuard.sv
module wrRecoveryGuard
  import wrg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cmdValid,
  input  logic [2:0]        cmdCode,
  input  logic [BANK_W-1:0] cmdBank,
  input  logic              cmdA12,
  input  logic [CFG_W-1:0]  cfgAl,
  input  logic [CFG_W-1:0]  cfgCwl,
  input  logic [1:0]        cfgBurst,
  input  logic [CFG_W-1:0]  cfgTwr,
  output logic [BANKS-1:0]  preOk,
  output logic              violation,
  output logic [BANK_W-1:0] violBank,
  output logic              violSticky
);
  ctlStrobe_t ctl;

  wrg_control u_ctl (
    .cmdValid(cmdValid), .cmdCode(cmdCode), .cmdBank(cmdBank), .cmdA12(cmdA12),
    .cfgAl(cfgAl), .cfgCwl(cfgCwl), .cfgBurst(cfgBurst), .cfgTwr(cfgTwr),
    .ctl(ctl)
  );

  wrg_datapath u_dp (
    .clk(clk), .rst(rst), .ctl(ctl), .preOk(preOk),
    .violation(violation), .violBank(violBank), .violSticky(violSticky)
  );

  // R1: state after reset
  p_reset_state_r1: assert property (@(posedge clk)
    $past(rst) |-> ((&preOk) && !violation && !violSticky && violBank == '0));
endmodule

// File: tb/tb_wrRecoveryGuard.sv
module tb_wrRecoveryGuard;
  logic       clk = 1'b0;
  logic       rst;
  logic       cmdValid;
  logic [2:0] cmdCode;
  logic [2:0] cmdBank;
  logic       cmdA12;
  logic [4:0] cfgAl, cfgCwl, cfgTwr;
  logic [1:0] cfgBurst;
  logic [7:0] preOk;
  logic       violation;
  logic [2:0] violBank;
  logic       violSticky;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  always #2.5 clk = ~clk;

  wrRecoveryGuard dut (
    .clk(clk), .rst(rst), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .cmdBank(cmdBank), .cmdA12(cmdA12), .cfgAl(cfgAl), .cfgCwl(cfgCwl),
    .cfgBurst(cfgBurst), .cfgTwr(cfgTwr), .preOk(preOk),
    .violation(violation), .violBank(violBank), .violSticky(violSticky)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive at a negedge for one cycle; returns at the next negedge
  task automatic issue(input logic [2:0] code, input logic [2:0] bank, input logic a12,
                       input logic valid = 1'b1);
    cmdValid = valid; cmdCode = code; cmdBank = bank; cmdA12 = a12;
    @(negedge clk);
    cmdValid = 1'b0; cmdCode = 3'b000;
  endtask

  // called in cycle 1 after a write; returns the reopening cycle
  task automatic waitOpen(input logic [2:0] bank, output int n);
    n = 1;
    while (!preOk[bank] && n < 120) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic drain();
    repeat (60) @(negedge clk);
  endtask

  task automatic setCfg(input int al, input int cwl, input logic [1:0] bm, input int twr);
    cfgAl = 5'(al); cfgCwl = 5'(cwl); cfgBurst = bm; cfgTwr = 5'(twr);
  endtask

  task automatic measure(input string req, input logic [1:0] bm, input logic a12,
                         input int al, input int cwl, input int twr, input int exp);
    int n;
    setCfg(al, cwl, bm, twr);
    issue(3'b001, 3'd3, a12);
    waitOpen(3'd3, n);
    check(n == exp, req, n, exp);
    drain();
  endtask

  task automatic tReset();
    check(preOk == 8'hFF, "R1 preOk", preOk, 255);
    check(!violation && !violSticky && violBank == 0, "R1 status",
          {violation, violSticky, violBank}, 0);
  endtask

  task automatic tModes();
    measure("R2 eight al0 cwl7 twr6", 2'b00, 1'b0, 0, 7, 6, 17);
    measure("R2 eight al0 cwl7 twr5", 2'b00, 1'b0, 0, 7, 5, 16);
    measure("R3 chop cwl5 twr5",      2'b10, 1'b1, 0, 5, 5, 12);
    measure("R4 otf a12=1",           2'b01, 1'b1, 0, 5, 5, 14);
    measure("R4 otf a12=0",           2'b01, 1'b0, 0, 5, 5, 12);
    measure("R4 code11 as eight",     2'b11, 1'b0, 0, 5, 5, 14);
    measure("R5 al2 cwl5",            2'b00, 1'b0, 2, 5, 5, 16);
  endtask

  task automatic tBanks();
    setCfg(0, 7, 2'b00, 6);
    issue(3'b001, 3'd4, 1'b0);
    check(preOk == 8'b1110_1111, "R6 only bank4 closed", preOk, 8'hEF);
    issue(3'b010, 3'd6, 1'b0);
    check(!violation && !violSticky, "R9 other-bank precharge", violation, 0);
    drain();
  endtask

  task automatic tRewrite();
    int n;
    setCfg(0, 7, 2'b00, 6);
    issue(3'b001, 3'd1, 1'b0);          // deadline 17
    setCfg(0, 7, 2'b10, 6);
    issue(3'b001, 3'd1, 1'b0);          // would be 1+15=16
    n = 2;
    while (!preOk[1] && n < 120) begin @(negedge clk); n++; end
    check(n == 17, "R7 shorter rewrite kept", n, 17);
    drain();
    setCfg(0, 7, 2'b00, 6);
    issue(3'b001, 3'd1, 1'b0);          // deadline 17
    @(negedge clk); @(negedge clk);     // now cycle 3
    issue(3'b001, 3'd1, 1'b0);          // deadline 3+17=20
    n = 4;
    while (!preOk[1] && n < 120) begin @(negedge clk); n++; end
    check(n == 20, "R7 later rewrite extends", n, 20);
    drain();
  endtask

  task automatic tViolation();
    setCfg(0, 5, 2'b00, 5);
    issue(3'b001, 3'd2, 1'b0);
    issue(3'b010, 3'd2, 1'b0);
    check(violation == 1'b1, "R8 pulse", violation, 1);
    check(violBank == 3'd2, "R8 bank", violBank, 2);
    check(violSticky == 1'b1, "R8 sticky", violSticky, 1);
    @(negedge clk);
    check(violation == 1'b0, "R8 single cycle", violation, 0);
    issue(3'b010, 3'd5, 1'b0);
    check(!violation && violBank == 3'd2 && violSticky, "R9 permitted precharge",
          {violation, violBank}, 2);
    drain();
  endtask

  task automatic tIgnored();
    setCfg(0, 5, 2'b00, 5);
    issue(3'b001, 3'd0, 1'b0);
    issue(3'b111, 3'd0, 1'b0);
    check(!violation, "R10 odd code no violation", violation, 0);
    issue(3'b011, 3'd6, 1'b0);
    check(preOk[6] == 1'b1, "R10 odd code no close", preOk[6], 1);
    issue(3'b010, 3'd0, 1'b0, 1'b0);
    check(!violation && violBank == 3'd2, "R10 invalid precharge", violation, 0);
    issue(3'b001, 3'd7, 1'b0, 1'b0);
    check(preOk[7] == 1'b1, "R10 invalid write", preOk[7], 1);
    drain();
  endtask

  initial begin
    rst = 1'b1; cmdValid = 1'b0; cmdCode = 3'b000; cmdBank = 3'd0; cmdA12 = 1'b0;
    setCfg(0, 5, 2'b00, 5);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    tReset();
    tModes();
    tBanks();
    tRewrite();
    tViolation();
    tIgnored();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
      end
    join_any
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule